// File: doc/BRIEF.md
# Block Floating-Point Exponent Tracker

This block keeps one shared exponent for a whole block of complex data while an in-place FFT engine runs its passes. During each pass it looks at every real and imaginary butterfly output it is shown and finds the largest magnitude, measured as the fewest redundant sign bits. At the end of the pass it picks the down-shift that the datapath must apply to its inputs during the next pass. That choice leaves room for the worst-case growth of the next pass: two bits for a radix-4 pass and one bit for a radix-2 pass. The fixed-point data therefore keeps as much dynamic range as it safely can.

Each shift applied to the data is charged to a signed two's-complement exponent. The convention is that the true result equals the fixed-point output multiplied by 2 raised to the negated exponent, so an exponent of -6 asks the consumer to multiply by 64. In inverse mode the 1/N normalisation is never applied to the data. It is folded into the exponent as +log2(N) when the transform starts, so no fixed-point precision is lost. The exponent saturates at its signed limits, and a sticky flag records that this happened. The butterfly datapath and its memories are outside the block.

Top module: `bfp_exp_tracker`

## Requirements
- R1: After reset the shift output is 2, the exponent is 0 and the overflow flag is 0.
- R2: A transform-start strobe loads the exponent with +LOG2_N in inverse mode (sampled in that cycle) or with 0 in forward mode. It sets the shift to 2, because the headroom of the first pass is unknown, and clears the overflow flag. All of this is visible one cycle later.
- R3: On a pass-end strobe the exponent drops, one cycle later, by the shift that was on the shift output during the cycle of the strobe (the shift in force for the pass that is ending).
- R4: The redundant sign-bit count of a DATA_W-bit two's-complement value is the number of bits directly below the MSB that equal the MSB (0x7FFF counts 0, 0x3FFF counts 1, 0x0000 and 0xFFFF count DATA_W-1). The pass headroom h is the smallest count over the real and imaginary parts of every sample with valid high since the last pass boundary, including a sample in the pass-end cycle. On pass-end the new shift is max(0, g-h), where g is 1 when the next-radix-2 input is high and 2 otherwise.
- R5: Samples presented with valid low have no effect. A pass with no valid sample yields h = DATA_W-1 and a new shift of 0.
- R6: When a decrement would go below -2^EXP_W the exponent holds at -2^EXP_W and the overflow flag rises. The flag stays high until the next transform start.
- R7: In a cycle with neither pass-end nor transform-start, the shift, the exponent and the overflow flag keep their values.
- R8: Transform-start takes priority over pass-end in the same cycle. The result is exactly that of R2, and the tracked headroom restarts empty.
- R9: Pass-start restarts the headroom tracking, and a valid sample in the pass-start cycle counts toward the new pass. Pass-end also restarts the tracking after it closes the pass. When both strobes come in the same cycle, the sample belongs to the ending pass and the new pass starts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfm_start | input | 1 | Transform-start strobe |
| inv_mode | input | 1 | 1 selects the inverse transform; sampled with xfm_start |
| pass_start | input | 1 | Pass-start strobe |
| pass_end | input | 1 | Pass-end strobe |
| nxt_radix2 | input | 1 | The pass after this pass-end is radix-2 |
| smp_valid | input | 1 | Butterfly output sample valid |
| smp_re | input | DATA_W | Real part of the sample, two's complement |
| smp_im | input | DATA_W | Imaginary part of the sample, two's complement |
| shift_amt | output | 2 | Down-shift for the datapath to apply in the current pass |
| exponent | output | EXP_W+1 | Shared block exponent, two's complement |
| exp_ovf | output | 1 | Sticky exponent saturation flag |

## Verification
Every result is registered. The shift, the exponent and the flag change on the rising edge that samples pass-end or transform-start, so each is due exactly one cycle after the strobe. The headroom from samples is folded in the same cycle and reaches the outputs only through that pass-end edge. The bench drives each stimulus on a falling edge and updates its own model for the following rising edge. It then compares all three outputs at the next falling edge, so every cycle is checked, including the idle cycles where R5 and R7 require nothing to move. After its asynchronous assertion, reset releases two cycles late, and the bench waits those cycles before its first check.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int SHIFT_W = 2;
  typedef logic [SHIFT_W-1:0] shift_t;

  // worst-case growth per pass type, in bits
  localparam shift_t GROW_R4     = 2'd2;
  localparam shift_t GROW_R2     = 2'd1;
  // headroom unknown before the first pass: assume worst case
  localparam shift_t SHIFT_FIRST = GROW_R4;
endpackage

// File: rtl/bfp_rsb_count.sv
module bfp_rsb_count #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  output logic [CNT_W-1:0]  rsb
);
  logic [DATA_W-2:0] diff;

  // a 1 marks a bit that differs from the sign
  assign diff = val[DATA_W-2:0] ^ {(DATA_W-1){val[DATA_W-1]}};

  // the highest differing bit sets the count; ascending scan lets it win
  always_comb begin
    rsb = CNT_W'(DATA_W-1);
    for (int i = 0; i < DATA_W-1; i++) begin
      if (diff[i]) rsb = CNT_W'(DATA_W-2-i);
    end
  end
endmodule

// File: rtl/bfp_headroom_track.sv
module bfp_headroom_track #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pass_start,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] rsb_a,
  input  logic [CNT_W-1:0] rsb_b,
  output logic [CNT_W-1:0] hr_now
);
  localparam logic [CNT_W-1:0] HR_EMPTY = CNT_W'(DATA_W-1);

  logic [CNT_W-1:0] hr_q;
  logic [CNT_W-1:0] hr_d;
  logic [CNT_W-1:0] smp_min;

  assign smp_min = (rsb_a < rsb_b) ? rsb_a : rsb_b;

  // running minimum including this cycle's sample
  always_comb begin
    hr_now = hr_q;
    if (smp_valid && (smp_min < hr_q)) hr_now = smp_min;
  end

  always_comb begin
    if (flush)           hr_d = HR_EMPTY;
    else if (pass_start) hr_d = smp_valid ? smp_min : HR_EMPTY;
    else                 hr_d = hr_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hr_q <= HR_EMPTY;
    else        hr_q <= hr_d;
  end
endmodule

// File: rtl/bfp_shift_select.sv
module bfp_shift_select
  import bfp_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0] hr,
  input  logic             nxt_radix2,
  output shift_t           shift_sel
);
  logic [CNT_W-1:0] grow;

  assign grow = nxt_radix2 ? CNT_W'(GROW_R2) : CNT_W'(GROW_R4);

  always_comb begin
    if (hr >= grow) shift_sel = '0;
    else            shift_sel = shift_t'(grow - hr);
  end
endmodule

// File: rtl/bfp_exp_accum.sv
module bfp_exp_accum
  import bfp_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int LOG2_N = 10,
  localparam int EW    = EXP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfm_start,
  input  logic                 inv_mode,
  input  logic                 pass_end,
  input  shift_t               cur_shift,
  output logic signed [EW-1:0] exp_q,
  output logic                 ovf_q
);
  localparam int EXP_MAX_I = (2 ** EXP_W) - 1;
  localparam int EXP_MIN_I = -(2 ** EXP_W);

  logic signed [EW-1:0] exp_d;
  logic                 ovf_d;
  logic                 upd_en;
  int                   dec_i;

  assign upd_en = xfm_start | pass_end;

  always_comb begin
    exp_d = exp_q;
    ovf_d = ovf_q;
    dec_i = int'(exp_q) - int'(cur_shift);
    if (xfm_start) begin
      if (inv_mode && (LOG2_N > EXP_MAX_I)) begin
        exp_d = EW'(EXP_MAX_I);
        ovf_d = 1'b1;
      end else begin
        exp_d = inv_mode ? EW'(LOG2_N) : '0;
        ovf_d = 1'b0;
      end
    end else if (pass_end) begin
      if (dec_i < EXP_MIN_I) begin
        exp_d = EW'(EXP_MIN_I);
        ovf_d = 1'b1;
      end else begin
        exp_d = EW'(dec_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      exp_q <= exp_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/bfp_exp_tracker.sv
module bfp_exp_tracker
  import bfp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 5,
  parameter int LOG2_N = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfm_start,
  input  logic              inv_mode,
  input  logic              pass_start,
  input  logic              pass_end,
  input  logic              nxt_radix2,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_re,
  input  logic [DATA_W-1:0] smp_im,
  output logic [1:0]        shift_amt,
  output logic [EXP_W:0]    exponent,
  output logic              exp_ovf
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int LANES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       arst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n_sync = rst_sync_q[1];

  // sign-bit counters, one per component
  logic [DATA_W-1:0] lane_val [LANES];
  logic [CNT_W-1:0]  lane_rsb [LANES];

  assign lane_val[0] = smp_re;
  assign lane_val[1] = smp_im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfp_rsb_count #(.DATA_W(DATA_W)) u_rsb (
      .val (lane_val[g]),
      .rsb (lane_rsb[g])
    );
  end

  logic [CNT_W-1:0] hr_now;
  logic             hr_flush;

  assign hr_flush = xfm_start | pass_end;

  bfp_headroom_track #(.DATA_W(DATA_W)) u_track (
    .clk        (clk),
    .rst_n      (arst_n_sync),
    .flush      (hr_flush),
    .pass_start (pass_start),
    .smp_valid  (smp_valid),
    .rsb_a      (lane_rsb[0]),
    .rsb_b      (lane_rsb[1]),
    .hr_now     (hr_now)
  );

  shift_t shift_sel;

  bfp_shift_select #(.DATA_W(DATA_W)) u_sel (
    .hr         (hr_now),
    .nxt_radix2 (nxt_radix2),
    .shift_sel  (shift_sel)
  );

  // shift register: next-state and register processes
  shift_t shift_q;
  shift_t shift_d;
  logic   shift_en;

  assign shift_en = xfm_start | pass_end;

  always_comb begin
    if (xfm_start) shift_d = SHIFT_FIRST;
    else           shift_d = shift_sel;
  end

  always_ff @(posedge clk or negedge arst_n_sync) begin
    if (!arst_n_sync)  shift_q <= SHIFT_FIRST;
    else if (shift_en) shift_q <= shift_d;
  end

  logic signed [EXP_W:0] exp_q;
  logic                  ovf_q;

  bfp_exp_accum #(.EXP_W(EXP_W), .LOG2_N(LOG2_N)) u_exp (
    .clk       (clk),
    .rst_n     (arst_n_sync),
    .xfm_start (xfm_start),
    .inv_mode  (inv_mode),
    .pass_end  (pass_end),
    .cur_shift (shift_q),
    .exp_q     (exp_q),
    .ovf_q     (ovf_q)
  );

  assign shift_amt = shift_q;
  assign exponent  = exp_q;
  assign exp_ovf   = ovf_q;
endmodule

// File: rtl/bfp_exp_tracker_chk.sv
module bfp_exp_tracker_chk #(
  parameter int EXP_W  = 5,
  parameter int LOG2_N = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           xfm_start,
  input logic           inv_mode,
  input logic           pass_end,
  input logic           nxt_radix2,
  input logic [1:0]     shift_amt,
  input logic [EXP_W:0] exponent,
  input logic           exp_ovf
);
  localparam int EXP_MAX_I = (2 ** EXP_W) - 1;
  localparam int INIT_INV  = (LOG2_N > EXP_MAX_I) ? EXP_MAX_I : LOG2_N;

  int exp_i;
  assign exp_i = int'($signed(exponent));

  // R2: start loads the mode-dependent exponent and the first-pass shift
  p_start_exp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfm_start |=> (exp_i == ($past(inv_mode) ? INIT_INV : 0)));
  p_start_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfm_start |=> (shift_amt == 2'd2));

  // R3: a pass end never raises the exponent
  p_exp_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !xfm_start) |=> (exp_i <= int'($signed($past(exponent)))));

  // R4: shift never exceeds the growth of the pass it protects
  p_shift_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_amt <= 2'd2);
  p_shift_r2pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !xfm_start && nxt_radix2) |=> (shift_amt <= 2'd1));

  // R6: overflow flag is sticky until a new transform
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_ovf && !xfm_start) |=> exp_ovf);

  // R7: nothing moves without a strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfm_start && !pass_end) |=>
      ($stable(exponent) && $stable(shift_amt) && $stable(exp_ovf)));
endmodule

bind bfp_exp_tracker bfp_exp_tracker_chk #(.EXP_W(EXP_W), .LOG2_N(LOG2_N)) u_chk (
  .clk        (clk),
  .rst_n      (arst_n_sync),
  .xfm_start  (xfm_start),
  .inv_mode   (inv_mode),
  .pass_end   (pass_end),
  .nxt_radix2 (nxt_radix2),
  .shift_amt  (shift_amt),
  .exponent   (exponent),
  .exp_ovf    (exp_ovf)
);

// File: tb/test_bfp_exp_tracker.sv
module test_bfp_exp_tracker;
  localparam int DATA_W = 16;
  localparam int EXP_W  = 5;
  localparam int LOG2_N = 10;
  localparam int EXP_MAX = (2 ** EXP_W) - 1;
  localparam int EXP_MIN = -(2 ** EXP_W);
  localparam int HR_EMPTY = DATA_W - 1;

  logic              clk;
  logic              rst_n;
  logic              xfm_start, inv_mode, pass_start, pass_end, nxt_radix2, smp_valid;
  logic [DATA_W-1:0] smp_re, smp_im;
  logic [1:0]        shift_amt;
  logic [EXP_W:0]    exponent;
  logic              exp_ovf;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model state
  int m_exp, m_shift, m_ovf, m_h;

  bfp_exp_tracker #(.DATA_W(DATA_W), .EXP_W(EXP_W), .LOG2_N(LOG2_N)) i_bfp_exp_tracker (
    .clk(clk), .rst_n(rst_n), .xfm_start(xfm_start), .inv_mode(inv_mode),
    .pass_start(pass_start), .pass_end(pass_end), .nxt_radix2(nxt_radix2),
    .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im),
    .shift_amt(shift_amt), .exponent(exponent), .exp_ovf(exp_ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  function automatic int rsb_m(input logic [DATA_W-1:0] v);
    int c = 0;
    for (int i = DATA_W-2; i >= 0; i--) begin
      if (v[i] != v[DATA_W-1]) break;
      c++;
    end
    return c;
  endfunction

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // update the model from the inputs now driven, clock once, compare
  task automatic tick(input string tag);
    int smin, hnow, g, e;
    smin = rsb_m(smp_re);
    if (rsb_m(smp_im) < smin) smin = rsb_m(smp_im);
    hnow = (smp_valid && smin < m_h) ? smin : m_h;
    if (xfm_start) begin
      m_exp   = inv_mode ? ((LOG2_N > EXP_MAX) ? EXP_MAX : LOG2_N) : 0;
      m_ovf   = (inv_mode && LOG2_N > EXP_MAX) ? 1 : 0;
      m_shift = 2;
      m_h     = HR_EMPTY;
    end else if (pass_end) begin
      g = nxt_radix2 ? 1 : 2;
      e = m_exp - m_shift;
      if (e < EXP_MIN) begin
        e = EXP_MIN;
        m_ovf = 1;
      end
      m_exp   = e;
      m_shift = (hnow >= g) ? 0 : g - hnow;
      m_h     = HR_EMPTY;
    end else if (pass_start) begin
      m_h = smp_valid ? smin : HR_EMPTY;
    end else begin
      m_h = hnow;
    end
    @(posedge clk);
    @(negedge clk);
    check_val(tag, "shift", int'(shift_amt), m_shift);
    check_val(tag, "exponent", int'($signed(exponent)), m_exp);
    check_val(tag, "overflow", int'(exp_ovf), m_ovf);
    xfm_start = 0; pass_start = 0; pass_end = 0; smp_valid = 0; nxt_radix2 = 0;
  endtask

  task automatic put(input logic v, input logic [DATA_W-1:0] re, input logic [DATA_W-1:0] im);
    smp_valid = v; smp_re = re; smp_im = im;
  endtask

  task automatic start_xfm(input logic inv, input string tag);
    xfm_start = 1; inv_mode = inv;
    tick(tag);
  endtask

  // one pass: start, quiet samples, one peak sample, end
  task automatic run_pass(input int n, input logic r2, input logic [DATA_W-1:0] peak, input string tag);
    pass_start = 1;
    tick(tag);
    for (int i = 0; i < n; i++) begin
      put(1'b1, 16'h0003, 16'hFFFC);
      tick(tag);
    end
    put(1'b1, 16'h0001, peak);
    tick(tag);
    pass_end = 1; nxt_radix2 = r2;
    tick(tag);
  endtask

  function automatic logic [DATA_W-1:0] rnd_val();
    logic [DATA_W-1:0] x;
    x = DATA_W'($urandom) >> ($urandom % DATA_W);
    return ($urandom % 2) ? x : ~x;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; xfm_start = 0; inv_mode = 0; pass_start = 0; pass_end = 0;
    nxt_radix2 = 0; smp_valid = 0; smp_re = '0; smp_im = '0;
    m_exp = 0; m_shift = 2; m_ovf = 0; m_h = HR_EMPTY;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val("R1", "shift", int'(shift_amt), 2);
    check_val("R1", "exponent", int'($signed(exponent)), 0);
    check_val("R1", "overflow", int'(exp_ovf), 0);

    // R2 forward start
    start_xfm(1'b0, "R2");
    // R4 directed headroom cases; R3 charges shift in force
    run_pass(3, 1'b0, 16'h7FFF, "R4");  // count 0 -> shift 2
    run_pass(3, 1'b0, 16'h3FFF, "R4");  // count 1 -> shift 1
    run_pass(2, 1'b0, 16'h1FFF, "R4");  // count 2 -> shift 0
    run_pass(2, 1'b1, 16'h3FFF, "R4");  // radix-2, count 1 -> 0
    run_pass(2, 1'b1, 16'h8000, "R4");  // negative, count 0 -> 1
    run_pass(2, 1'b0, 16'hC000, "R3");  // count 1 -> shift 1
    // R5 empty pass and ignored samples
    pass_start = 1;
    tick("R5");
    for (int i = 0; i < 4; i++) begin
      put(1'b0, 16'h7FFF, 16'h8000);
      tick("R5");
    end
    pass_end = 1;
    tick("R5");
    // R7 hold with samples but no strobes
    for (int i = 0; i < 5; i++) begin
      put(1'b1, 16'h7FFF, 16'h7FFF);
      tick("R7");
    end
    pass_end = 1;
    tick("R7");
    // R9 sample in pass-start cycle counts
    pass_start = 1; put(1'b1, 16'h4000, 16'h0000);
    tick("R9");
    pass_end = 1;
    tick("R9");
    // R9 both strobes: sample closes old pass, new one empty
    put(1'b1, 16'h0100, 16'h0000);
    tick("R9");
    pass_start = 1; pass_end = 1; put(1'b1, 16'h7000, 16'h0000);
    tick("R9");
    pass_end = 1;
    tick("R9");
    // R2 inverse start
    start_xfm(1'b1, "R2");
    // R6 saturation
    for (int p = 0; p < 24; p++) run_pass(1, 1'b0, 16'h7FFF, "R6");
    check_val("R6", "overflow set", int'(exp_ovf), 1);
    check_val("R6", "exponent at limit", int'($signed(exponent)), EXP_MIN);
    // R8 start wins over pass end
    put(1'b1, 16'h7FFF, 16'h7FFF); xfm_start = 1; pass_end = 1; inv_mode = 0;
    tick("R8");
    pass_end = 1;
    tick("R8");
    // random passes
    for (int p = 0; p < 400; p++) begin
      if (p % 37 == 0) start_xfm(1'($urandom % 2), "R2");
      pass_start = 1;
      put(1'($urandom % 2), rnd_val(), rnd_val());
      tick("R9");
      for (int i = 0; i < int'($urandom % 12); i++) begin
        put(1'($urandom % 4 != 0), rnd_val(), rnd_val());
        tick("R4");
      end
      pass_end = 1; nxt_radix2 = 1'($urandom % 3 == 0);
      put(1'($urandom % 2), rnd_val(), rnd_val());
      tick("R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule